// File: doc/BRIEF.md
# Transmit Data Link Overhead Insertion Port

This block sits in the transmit serial path of a T1/E1 framer and overwrites the data link overhead slots of the outgoing bit stream. The transmit serial clock is represented by a one-cycle bit strobe, `bit_stb`, on a faster core clock `clk`. The block keeps its own bit and frame position counters on that strobe. In T1 mode the slots are the data link framing bits of an ESF multiframe. In E1 mode they are the enabled national bits Sa4 to Sa8 of the frames that do not carry the alignment word.

When the overhead port is the selected source, the block asks the external data link equipment for each bit with a demand clock, `oh_clk`. The clock rises once ahead of every slot to be filled. The equipment changes `oh_in` on that rising edge. The block captures `oh_in` on the following falling edge and puts the captured bit into the stream at the slot. If the source select picks the serial passthrough, the stream leaves unchanged. If it picks the HDLC controller, a bit supplied on `hdlc_bit` fills the slots. With either of these two sources the demand clock stays low and `oh_in` is ignored.

A small state machine paces the demand clock:
- States: `DC_IDLE` (no request pending), `DC_HIGH` (demand clock high for one core cycle) and `DC_HELD` (bit captured, waiting for its slot).
- Transitions:
  - `DC_IDLE`→`DC_HIGH` on a strobe whose next position is a slot.
  - `DC_HIGH`→`DC_HELD` on the next cycle, capturing `oh_in`.
  - `DC_HELD`→`DC_HIGH` on the slot's strobe when the following position is also a slot.
  - `DC_HELD`→`DC_IDLE` on the slot's strobe otherwise.
  - Any state→`DC_IDLE` when the overhead port is not selected.

Top module: `tx_dl_ovh_insert`

## Requirements
- R1: In T1 mode (`mode`=0), a frame is 193 bit positions (index 0 is the framing bit) and a multiframe is 24 frames indexed 0 to 23. With `dl_src`=00 the framing bit of each even-indexed frame (0, 2, ..., 22) is replaced by the bit captured from `oh_in`.
- R2: Every position that is not a data link slot leaves on `ser_out` equal to the `ser_in` bit strobed at that position. This includes the framing bits of odd-indexed T1 frames and all E1 alignment frames.
- R3: In E1 mode (`mode`=1), a frame is 256 positions. Frames alternate, with even index meaning alignment frame and odd index meaning non-alignment frame. In odd frames, positions 3 to 7 are Sa4 to Sa8. With `dl_src`=00, Sa(4+k) is replaced by the captured `oh_in` bit when `sa_en[k]` is 1.
- R4: An Sa bit whose `sa_en` bit is 0 passes through unchanged, and no demand clock pulse is made for it.
- R5: `oh_clk` rises only in the core cycle right after a strobe whose next position is an enabled slot with `dl_src`=00. It stays high for exactly one core cycle. The number of pulses equals the number of slots requested.
- R6: `oh_in` is sampled at the core clock edge where `oh_clk` falls. That captured value, not a later one, is inserted at the next strobe.
- R7: `ser_out` changes only at the clock edge that samples `bit_stb` high, one cycle after the strobe, and holds between strobes. Strobes are at least two core cycles apart.
- R8: With `dl_src`=10 (HDLC), each slot carries the `hdlc_bit` value present with its strobe, `oh_in` is ignored, and `oh_clk` stays low.
- R9: With `dl_src`=01 or 11 (serial passthrough), `ser_out` repeats `ser_in` at every position and `oh_clk` stays low.
- R10: Synchronous active-high `rst` sets the position to frame 0 bit 0, drives `oh_clk` and `ser_out` low, and leaves no captured bit. A slot reached with no demand pulse before it (the first T1 slot after reset) passes `ser_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe marking each serial bit |
| mode | input | 1 | 0 = T1 ESF, 1 = E1 |
| dl_src | input | 2 | Data link source: 00 port, 01/11 serial, 10 HDLC |
| sa_en | input | SA_NUM | Per-bit enable for Sa4..Sa8 (bit 0 = Sa4) |
| ser_in | input | 1 | Incoming serial bit, valid with the strobe |
| hdlc_bit | input | 1 | Data link bit from the HDLC controller |
| oh_in | input | 1 | Overhead bit from external equipment |
| oh_clk | output | 1 | Demand clock to external equipment |
| ser_out | output | 1 | Outgoing serial bit, registered |

## Verification
The assertions assume that `bit_stb` never stays high for two cycles in a row. They also assume that `mode`, `dl_src` and `sa_en` change only while `rst` is high, so the demand clock always has room to rise and fall between bits. The stimulus follows both rules. It leaves one to three idle cycles after each strobe and changes the configuration only inside a reset at the start of each run. Within these limits, `oh_in` is randomised on every core cycle. Any capture on the wrong edge therefore inserts a different bit.

// File: rtl/tx_dl_pkg.sv
package tx_dl_pkg;

    typedef enum logic {
        LINE_T1 = 1'b0,
        LINE_E1 = 1'b1
    } line_mode_e;

    typedef enum logic [1:0] {
        SRC_OHPORT  = 2'b00,
        SRC_SERIAL  = 2'b01,
        SRC_HDLC    = 2'b10,
        SRC_SERIAL2 = 2'b11
    } dl_src_e;

    typedef enum logic [1:0] {
        DC_IDLE = 2'b00,
        DC_HIGH = 2'b01,
        DC_HELD = 2'b10
    } dc_state_e;

endpackage

// File: rtl/tx_dl_pos_ctr.sv
module tx_dl_pos_ctr
    import tx_dl_pkg::*;
#(
    parameter int T1_BITS   = 193,
    parameter int T1_FRAMES = 24,
    parameter int E1_BITS   = 256,
    parameter int E1_FRAMES = 2,
    parameter int SA_FIRST  = 3,
    parameter int SA_NUM    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  line_mode_e        mode,
    input  logic [SA_NUM-1:0] sa_en,
    output logic              cur_dl,
    output logic              nxt_dl
);

    localparam int BITS_MAX = (T1_BITS > E1_BITS) ? T1_BITS : E1_BITS;
    localparam int FRM_MAX  = (T1_FRAMES > E1_FRAMES) ? T1_FRAMES : E1_FRAMES;
    localparam int BW       = (BITS_MAX > 2) ? $clog2(BITS_MAX) : 1;
    localparam int FW       = (FRM_MAX > 2) ? $clog2(FRM_MAX) : 1;

    logic [BW-1:0] bit_q, bit_n, last_bit;
    logic [FW-1:0] frm_q, frm_n, last_frm;

    function automatic logic slot_hit(input line_mode_e md,
                                      input logic [SA_NUM-1:0] en,
                                      input logic [BW-1:0] b,
                                      input logic [FW-1:0] f);
        logic hit;
        hit = 1'b0;
        if (md == LINE_T1) begin
            hit = (b == '0) && !f[0];
        end else if (f[0]) begin
            for (int k = 0; k < SA_NUM; k++) begin
                if (b == BW'(SA_FIRST + k) && en[k]) hit = 1'b1;
            end
        end
        return hit;
    endfunction

    always_comb begin
        last_bit = (mode == LINE_E1) ? BW'(E1_BITS - 1) : BW'(T1_BITS - 1);
        last_frm = (mode == LINE_E1) ? FW'(E1_FRAMES - 1) : FW'(T1_FRAMES - 1);
        bit_n    = (bit_q == last_bit) ? '0 : bit_q + 1'b1;
        frm_n    = frm_q;
        if (bit_q == last_bit) begin
            frm_n = (frm_q == last_frm) ? '0 : frm_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= '0;
            frm_q <= '0;
        end else if (bit_stb) begin
            bit_q <= bit_n;
            frm_q <= frm_n;
        end
    end

    assign cur_dl = slot_hit(mode, sa_en, bit_q, frm_q);
    assign nxt_dl = slot_hit(mode, sa_en, bit_n, frm_n);

endmodule

// File: rtl/tx_dl_demand_fsm.sv
module tx_dl_demand_fsm
    import tx_dl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic port_sel,
    input  logic nxt_dl,
    input  logic oh_in,
    output logic oh_clk,
    output logic oh_bit,
    output logic oh_vld
);

    dc_state_e state_q, state_d;
    logic      cap_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DC_IDLE: if (port_sel && bit_stb && nxt_dl) state_d = DC_HIGH;
            DC_HIGH: state_d = port_sel ? DC_HELD : DC_IDLE;
            DC_HELD: begin
                if (!port_sel)   state_d = DC_IDLE;
                else if (bit_stb) state_d = nxt_dl ? DC_HIGH : DC_IDLE;
            end
            default: state_d = DC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= DC_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)                     cap_q <= 1'b0;
        else if (state_q == DC_HIGH) cap_q <= oh_in;
    end

    always_comb begin
        oh_clk = (state_q == DC_HIGH);
        oh_vld = (state_q == DC_HELD);
        oh_bit = cap_q;
    end

endmodule

// File: rtl/tx_dl_ovh_insert.sv
module tx_dl_ovh_insert
    import tx_dl_pkg::*;
#(
    parameter int T1_BITS   = 193,
    parameter int T1_FRAMES = 24,
    parameter int E1_BITS   = 256,
    parameter int E1_FRAMES = 2,
    parameter int SA_FIRST  = 3,
    parameter int SA_NUM    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic              mode,
    input  logic [1:0]        dl_src,
    input  logic [SA_NUM-1:0] sa_en,
    input  logic              ser_in,
    input  logic              hdlc_bit,
    input  logic              oh_in,
    output logic              oh_clk,
    output logic              ser_out
);

    line_mode_e line_mode;
    dl_src_e    src;
    logic       cur_dl, nxt_dl;
    logic       oh_bit, oh_vld;
    logic       bit_sel;

    assign line_mode = line_mode_e'(mode);
    assign src       = dl_src_e'(dl_src);

    tx_dl_pos_ctr #(
        .T1_BITS  (T1_BITS),
        .T1_FRAMES(T1_FRAMES),
        .E1_BITS  (E1_BITS),
        .E1_FRAMES(E1_FRAMES),
        .SA_FIRST (SA_FIRST),
        .SA_NUM   (SA_NUM)
    ) u_pos (
        .clk    (clk),
        .rst    (rst),
        .bit_stb(bit_stb),
        .mode   (line_mode),
        .sa_en  (sa_en),
        .cur_dl (cur_dl),
        .nxt_dl (nxt_dl)
    );

    tx_dl_demand_fsm u_dem (
        .clk     (clk),
        .rst     (rst),
        .bit_stb (bit_stb),
        .port_sel(src == SRC_OHPORT),
        .nxt_dl  (nxt_dl),
        .oh_in   (oh_in),
        .oh_clk  (oh_clk),
        .oh_bit  (oh_bit),
        .oh_vld  (oh_vld)
    );

    always_comb begin
        bit_sel = ser_in;
        if (cur_dl) begin
            unique case (src)
                SRC_OHPORT: if (oh_vld) bit_sel = oh_bit;
                SRC_HDLC:   bit_sel = hdlc_bit;
                default:    bit_sel = ser_in;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          ser_out <= 1'b0;
        else if (bit_stb) ser_out <= bit_sel;
    end

endmodule

// File: rtl/tx_dl_ovh_insert_chk.sv
module tx_dl_ovh_insert_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_stb,
    input logic [1:0] dl_src,
    input logic       ser_in,
    input logic       oh_clk,
    input logic       ser_out
);

    // R7
    stb_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |=> $stable(ser_out));

    // R5
    dem_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        oh_clk |=> !oh_clk);

    // R5
    dem_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oh_clk) |-> $past(bit_stb));

    // R8
    dem_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (dl_src != 2'b00) |=> !oh_clk);

    // R9
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && dl_src[0]) |=> (ser_out == $past(ser_in)));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!oh_clk && !ser_out));

endmodule

bind tx_dl_ovh_insert tx_dl_ovh_insert_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .bit_stb(bit_stb),
    .dl_src (dl_src),
    .ser_in (ser_in),
    .oh_clk (oh_clk),
    .ser_out(ser_out)
);

// File: tb/tx_dl_ovh_insert_tb.sv
module tx_dl_ovh_insert_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0;
    logic       mode = 1'b0;
    logic [1:0] dl_src = 2'b00;
    logic [4:0] sa_en = 5'b11111;
    logic       ser_in = 1'b0;
    logic       hdlc_bit = 1'b0;
    logic       oh_in = 1'b0;
    logic       oh_clk;
    logic       ser_out;

    always #5 clk = ~clk;

    tx_dl_ovh_insert u_dut (
        .clk     (clk),
        .rst     (rst),
        .bit_stb (bit_stb),
        .mode    (mode),
        .dl_src  (dl_src),
        .sa_en   (sa_en),
        .ser_in  (ser_in),
        .hdlc_bit(hdlc_bit),
        .oh_in   (oh_in),
        .oh_clk  (oh_clk),
        .ser_out (ser_out)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    m_bit = 0, m_frm = 0;
    bit    m_clk = 0, m_out = 0, m_have = 0, m_cap = 0;
    string m_tag = "R10";
    int    dem_exp = 0, dem_seen = 0;
    bit    prev_clk = 0;
    bit    done = 0;

    function automatic bit is_slot(bit md, logic [4:0] en, int b, int f);
        if (!md) return (b == 0) && (f % 2 == 0);
        if (f % 2 == 1 && b >= 3 && b <= 7) return en[b-3];
        return 1'b0;
    endfunction

    task automatic check(bit cond, string req, int act, int exp);
        n_cmp++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_bit = 0; m_frm = 0; m_clk = 0; m_out = 0; m_have = 0; m_cap = 0;
            dem_exp = 0; m_tag = "R10";
        end else begin
            m_tag = "R7";
            if (m_clk) begin
                m_cap  = oh_in;   // R6: sampled where the demand clock falls
                m_have = 1;
                m_clk  = 0;
            end
            if (bit_stb) begin
                if (is_slot(mode, sa_en, m_bit, m_frm)) begin
                    if (dl_src == 2'b00) begin
                        if (m_have) begin m_out = m_cap; m_tag = mode ? "R3" : "R1"; end
                        else begin m_out = ser_in; m_tag = "R10"; end
                    end else if (dl_src == 2'b10) begin
                        m_out = hdlc_bit; m_tag = "R8";
                    end else begin
                        m_out = ser_in; m_tag = "R9";
                    end
                end else begin
                    m_out = ser_in;
                    if (dl_src[0]) m_tag = "R9";
                    else if (mode && m_frm % 2 == 1 && m_bit >= 3 && m_bit <= 7) m_tag = "R4";
                    else m_tag = "R2";
                end
                m_have = 0;
                m_bit++;
                if (m_bit == (mode ? 256 : 193)) begin
                    m_bit = 0;
                    m_frm++;
                    if (m_frm == (mode ? 2 : 24)) m_frm = 0;
                end
                if (dl_src == 2'b00 && is_slot(mode, sa_en, m_bit, m_frm)) begin
                    m_clk = 1;
                    dem_exp++;
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(ser_out == m_out, m_tag, ser_out, m_out);
            check(oh_clk == m_clk, "R5", oh_clk, m_clk);
            if (oh_clk && !prev_clk) dem_seen++;
        end
        prev_clk = oh_clk;
    end

    always @(negedge clk) oh_in <= 1'($urandom);

    task automatic run_seg(bit md, logic [1:0] src, logic [4:0] en, int nbits);
        rst = 1'b1;
        bit_stb = 1'b0;
        mode = md; dl_src = src; sa_en = en;
        repeat (2) @(negedge clk);
        // R10 reset state
        check(oh_clk == 1'b0, "R10", oh_clk, 0);
        check(ser_out == 1'b0, "R10", ser_out, 0);
        dem_seen = 0;
        rst = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            bit_stb  = 1'b1;
            ser_in   = 1'($urandom);
            hdlc_bit = 1'($urandom);
            @(negedge clk);
            bit_stb = 1'b0;
            repeat (1 + ($urandom % 3)) @(negedge clk);
        end
        @(negedge clk);
        // R5 pulse count per run; R4 masked slots make no pulses
        check(dem_seen == dem_exp, "R5", dem_seen, dem_exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        run_seg(1'b0, 2'b00, 5'b11111, 5000);  // R1 R2 R6 R10
        run_seg(1'b1, 2'b00, 5'b11111, 1600);  // R3
        run_seg(1'b1, 2'b00, 5'b10101, 1600);  // R4
        run_seg(1'b1, 2'b00, 5'b00000, 600);   // R4 no pulses
        run_seg(1'b1, 2'b10, 5'b11111, 1200);  // R8
        run_seg(1'b0, 2'b10, 5'b11111, 1200);  // R8
        run_seg(1'b0, 2'b01, 5'b11111, 500);   // R9
        run_seg(1'b1, 2'b11, 5'b11111, 600);   // R9
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 190000);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule